// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Load Controller

This block is the digital front end of an 8-bit voltage-output converter. It sits between a host's parallel bus strobes (chip select, write, load, clear, power-down, all active low and asynchronous to the system clock) and the converter core. It delivers the code the core converts, plus a power-down flag.

Data enters an input register when a write cycle ends. A second register, the DAC register, feeds the converter. The level of the load strobe at the end of each write picks how the DAC register updates:
- Load low: the DAC register copies the new data at once.
- Load high: the DAC register holds its value until a later falling edge of load, so several converters can change together.

A power-on state keeps the output at zero until the first write. A clear input forces the output to zero at once. Strobe pulses that are too short raise a sticky protocol error flag.

All strobes except clear pass through two-flop synchronizers before their edges are detected. The data bus is delayed by the same number of stages, so it lines up with the strobes. Clear asserts asynchronously and releases synchronously.

Top module: `dac_dbuf_ctrl`

## Requirements
- R1: A write lasts while both `cs_n` and `wr_n` are low. When it ends, the input register takes the value `din` had during the write.
- R2: If `ld_n` is low when a write ends, `code` takes the written value. This happens no later than 5 clock cycles after the strobes rise.
- R3: If `ld_n` is high when a write ends (outside the power-on state), `code` keeps its value. At the next falling edge of `ld_n`, `code` takes the input register value.
- R4: If `ld_n` was pulled low for a synchronous update and is still low when a later write ends, that write is an automatic update.
- R5: While `clr_n` is low, `code` is zero at once, with no clock edge needed. The DAC register is zeroed and stays zero through any write or load edge during the clear. The input register still captures writes. After release, `code` stays zero until the next update.
- R6: After reset, `code`, `pd_flag` and `proto_err` are 0. In the power-on state, the first completed write updates `code` whatever the level of `ld_n`, and that write ends the power-on state.
- R7: `pd_flag` is the inverse of `pd_n` after synchronization. Power-down changes neither register; writes made during power-down are kept.
- R8: A write or load low pulse shorter than `min_pulse` cycles (counted after synchronization) sets `proto_err`. `proto_err` then stays set.
- R9: Driving `err_clr` high for a cycle clears `proto_err`.
- R10: A low `wr_n` with `cs_n` high is not a write and changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, which also enters the power-on state |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| ld_n | input | 1 | Load strobe, active low, asynchronous |
| clr_n | input | 1 | Clear, active low, asynchronous assert |
| pd_n | input | 1 | Power-down request, active low |
| din | input | 8 | Parallel data bus |
| min_pulse | input | 8 | Minimum legal strobe width in clock cycles |
| err_clr | input | 1 | Clears the protocol error flag |
| code | output | 8 | Code presented to the converter |
| pd_flag | output | 1 | High while power-down is requested |
| proto_err | output | 1 | Sticky short-pulse error flag |

## Verification
Two pairs of events can fall in the same cycle:
- A write ending while clear is held low. The bench holds `clr_n` low across a full write with `ld_n` low, which would normally be an automatic update. It then requires `code` to stay zero after clear releases, and shows the captured data only after a later load edge.
- A load falling edge meeting the end of a write. The bench keeps `ld_n` low from a synchronous load into the following write. It requires that write to reach `code` directly, as an automatic update, with no further load edge.

// File: rtl/dac_dbuf_pkg.sv
`timescale 1ns/1ps
package dac_dbuf_pkg;
  // how the DAC register reacts to a completed write
  typedef enum logic [0:0] {
    UPD_AUTO = 1'b0,
    UPD_SYNC = 1'b1
  } upd_mode_e;

  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/dac_sync.sv
`timescale 1ns/1ps
// multi-stage synchronizer / aligned delay line with a reset value
module dac_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dac_pulse_mon.sv
`timescale 1ns/1ps
// measures low-pulse length of a synchronized strobe and flags short ones
module dac_pulse_mon #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [CW-1:0] min_len,
  output logic          prev_o,
  output logic          short_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q;
  logic          end_w;

  always_comb begin
    cnt_d = cnt_q;
    if (active) begin
      if (cnt_q != '1) cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= active;
    end
  end

  assign end_w   = act_q & ~active;
  assign short_o = end_w & (cnt_q < min_len);
  assign prev_o  = act_q;
endmodule

// File: rtl/dac_regs.sv
`timescale 1ns/1ps
// input register, DAC register and power-on state
module dac_regs
  import dac_dbuf_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] data_s,
  input  logic          wr_end,
  input  logic          ld_act,
  input  logic          ld_fall,
  input  logic          clr_ok,
  output logic [DW-1:0] in_q,
  output logic [DW-1:0] dac_q,
  output logic          por_q
);
  logic [DW-1:0] in_d, dac_d;
  logic          por_d;
  upd_mode_e     mode;

  always_comb begin
    mode  = ld_act ? UPD_AUTO : UPD_SYNC;
    in_d  = wr_end ? data_s : in_q;
    por_d = por_q & ~wr_end;
    dac_d = dac_q;
    if (!clr_ok) begin
      dac_d = '0;
    end else if (wr_end && (mode == UPD_AUTO || por_q)) begin
      dac_d = data_s;
    end else if (por_q) begin
      dac_d = in_q;           // transparent while in power-on state
    end else if (ld_fall) begin
      dac_d = in_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
      por_q <= 1'b1;
    end else begin
      in_q  <= in_d;
      dac_q <= dac_d;
      por_q <= por_d;
    end
  end
endmodule

// File: rtl/dac_dbuf_ctrl.sv
`timescale 1ns/1ps
module dac_dbuf_ctrl #(
  parameter int unsigned DW          = 8,
  parameter int unsigned CW          = 8,
  parameter int unsigned SYNC_STAGES = dac_dbuf_pkg::DEF_SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          ld_n,
  input  logic          clr_n,
  input  logic          pd_n,
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] min_pulse,
  input  logic          err_clr,
  output logic [DW-1:0] code,
  output logic          pd_flag,
  output logic          proto_err
);
  localparam int unsigned NCTL = 4;

  logic [NCTL-1:0] ctl_s;
  logic [DW-1:0]   data_s;
  logic            clr_ok;
  logic            clr_arst_n;
  logic            wr_act, ld_act;
  logic            wr_prev, ld_prev;
  logic            wr_short, ld_short;
  logic            wr_end, ld_fall;
  logic [DW-1:0]   in_q, dac_q;
  logic            por_q;
  logic            err_q, err_d;

  dac_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL({NCTL{1'b1}})) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, wr_n, ld_n, pd_n}), .q(ctl_s));

  dac_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(data_s));

  // clear: asynchronous assert, synchronous release
  assign clr_arst_n = rst_n & clr_n;
  dac_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_clr_sync (
    .clk(clk), .rst_n(clr_arst_n), .d(1'b1), .q(clr_ok));

  assign wr_act = ~ctl_s[3] & ~ctl_s[2];
  assign ld_act = ~ctl_s[1];

  dac_pulse_mon #(.CW(CW)) u_wr_mon (
    .clk(clk), .rst_n(rst_n), .active(wr_act), .min_len(min_pulse),
    .prev_o(wr_prev), .short_o(wr_short));

  dac_pulse_mon #(.CW(CW)) u_ld_mon (
    .clk(clk), .rst_n(rst_n), .active(ld_act), .min_len(min_pulse),
    .prev_o(ld_prev), .short_o(ld_short));

  assign wr_end  = wr_prev & ~wr_act;
  assign ld_fall = ~ld_prev & ld_act;

  dac_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .data_s(data_s), .wr_end(wr_end),
    .ld_act(ld_act), .ld_fall(ld_fall), .clr_ok(clr_ok),
    .in_q(in_q), .dac_q(dac_q), .por_q(por_q));

  always_comb begin
    err_d = err_q;
    if (err_clr)               err_d = 1'b0;
    if (wr_short || ld_short)  err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign code      = clr_ok ? dac_q : '0;
  assign pd_flag   = ~ctl_s[0];
  assign proto_err = err_q;
endmodule

// File: rtl/dac_dbuf_chk.sv
`timescale 1ns/1ps
module dac_dbuf_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_n,
  input logic          err_clr,
  input logic          proto_err,
  input logic [DW-1:0] code,
  input logic [DW-1:0] data_s,
  input logic          wr_end,
  input logic          ld_act,
  input logic          ld_fall,
  input logic          clr_ok,
  input logic [DW-1:0] in_q,
  input logic [DW-1:0] dac_q,
  input logic          por_q
);
  p_in_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> (in_q == $past(data_s)));

  p_auto_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && ld_act && clr_ok) |=> (dac_q == $past(data_s)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_end && !ld_fall && !por_q && clr_ok) |=> $stable(dac_q));

  p_clr_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n) |-> (code == '0));

  p_clr_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_ok) |=> (dac_q == '0));

  p_por_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    por_q |-> (in_q == '0));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_err && !err_clr) |=> proto_err);
endmodule

bind dac_dbuf_ctrl dac_dbuf_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .err_clr(err_clr),
  .proto_err(proto_err), .code(code), .data_s(data_s), .wr_end(wr_end),
  .ld_act(ld_act), .ld_fall(ld_fall), .clr_ok(clr_ok), .in_q(in_q),
  .dac_q(dac_q), .por_q(por_q));

// File: tb/sim_dac_dbuf_ctrl.sv
`timescale 1ns/1ps
module sim_dac_dbuf_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, cs_n, wr_n, ld_n, clr_n, pd_n, err_clr;
  logic [7:0] din, min_pulse, code;
  logic       pd_flag, proto_err;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  dac_dbuf_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
    .clr_n(clr_n), .pd_n(pd_n), .din(din), .min_pulse(min_pulse),
    .err_clr(err_clr), .code(code), .pd_flag(pd_flag), .proto_err(proto_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cycle(input logic [7:0] d, input int len);
    @(negedge clk); din = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (len) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic ld_pulse(input int len);
    @(negedge clk); ld_n = 1'b0;
    repeat (len) @(negedge clk);
    ld_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1; clr_n = 1'b1;
    pd_n = 1'b1; err_clr = 1'b0; din = 8'h00; min_pulse = 8'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 reset code", code, 8'h00);
    chk("R6 reset pd_flag", pd_flag, 1'b0);
    chk("R6 reset proto_err", proto_err, 1'b0);
  endtask

  task automatic t_por_and_sync();
    wr_cycle(8'h5A, 6);
    chk("R6 first write updates with load high", code, 8'h5A);
    wr_cycle(8'h33, 6);
    chk("R3 load high holds code", code, 8'h5A);
    ld_pulse(6);
    chk("R3 R1 load fall moves input register", code, 8'h33);
  endtask

  task automatic t_auto();
    @(negedge clk); ld_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_cycle(8'hC4, 6);
    chk("R2 automatic update", code, 8'hC4);
    wr_cycle(8'h0F, 6);
    chk("R2 second automatic update", code, 8'h0F);
    ld_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 load rise no change", code, 8'h0F);
  endtask

  task automatic t_ld_still_low();
    wr_cycle(8'h11, 6);
    chk("R3 deferred write", code, 8'h0F);
    @(negedge clk); ld_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R3 load fall update", code, 8'h11);
    wr_cycle(8'h22, 6);
    chk("R4 write during held load is automatic", code, 8'h22);
    ld_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_cs_gate();
    @(negedge clk); din = 8'h99; wr_n = 1'b0;
    repeat (6) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 write without select ignored", code, 8'h22);
    ld_pulse(6);
    chk("R10 input register unchanged", code, 8'h22);
  endtask

  task automatic t_clear();
    @(negedge clk); clr_n = 1'b0;
    #1;
    chk("R5 clear is immediate", code, 8'h00);
    @(negedge clk); ld_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_cycle(8'h77, 6);
    chk("R5 clear beats automatic write", code, 8'h00);
    ld_n = 1'b1;
    repeat (4) @(negedge clk);
    clr_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5 zero kept after release", code, 8'h00);
    ld_pulse(6);
    chk("R5 R1 write captured during clear", code, 8'h77);
  endtask

  task automatic t_pd();
    @(negedge clk); pd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 pd_flag set", pd_flag, 1'b1);
    chk("R7 code kept in power-down", code, 8'h77);
    wr_cycle(8'h44, 6);
    pd_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 pd_flag cleared", pd_flag, 1'b0);
    chk("R7 code after exit", code, 8'h77);
    ld_pulse(6);
    chk("R7 write in power-down preserved", code, 8'h44);
  endtask

  task automatic t_err();
    chk("R8 no error from legal pulses", proto_err, 1'b0);
    wr_cycle(8'h44, 2);
    chk("R8 short write flagged", proto_err, 1'b1);
    repeat (10) @(negedge clk);
    chk("R8 flag sticky", proto_err, 1'b1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 err_clr clears flag", proto_err, 1'b0);
    wr_cycle(8'h44, 6);
    chk("R8 legal write no flag", proto_err, 1'b0);
    ld_pulse(2);
    chk("R8 short load flagged", proto_err, 1'b1);
  endtask

  initial begin
    t_reset();
    t_por_and_sync();
    t_auto();
    t_ld_still_low();
    t_cs_gate();
    t_clear();
    t_pd();
    t_err();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule